// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus-facing part of a small byte-wide nonvolatile memory. It runs from a fast system clock and oversamples the two-wire serial bus. It finds START and STOP conditions, shifts bytes in and out, and answers on the ninth clock of each byte. It drives the data line only through an open-drain enable. The array is a register model whose depth is a parameter: 256, 512, 1024 or 2048 bytes.

A master selects the device with a 7-bit code. The code has the fixed prefix 1010, and its three low bits are compared with three chip-enable inputs. For depths above 256 bytes, the low bits of that code supply the upper address bits instead, and the matching chip-enable inputs are then not compared. Writes go through a 16-entry page buffer. A STOP on a byte boundary commits the buffer in a timed internal write cycle. While that cycle runs, the device does not answer its select code, so the master can poll until the write is done. Reads return data from an address counter that advances after every byte. A write-protect input lets the select byte and the address byte through, but refuses data bytes.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) opens a transfer at any point, including in the middle of one. Bytes clocked after a STOP and before the next START get no acknowledge. A STOP returns the block to idle with SDA released.
- R2: The select byte is 1010 in bits 7:4 and a read/write flag in bit 0 (1 means read). At the default depth, bits 3:1 must equal chip_en[2:0]. On a match the block pulls SDA low during the ninth clock. On a mismatch it gives no acknowledge and ignores the rest of the transfer.
- R3: While wr_ctl is high, the select byte and the address byte are acknowledged. Data bytes are not acknowledged, no location changes, and no write cycle starts.
- R4: In a write, the byte after the select byte sets the address. Each acknowledged data byte goes to that address, and only the low 4 address bits then advance. Bytes past the end of a 16-byte page therefore overwrite the start of the same page. The bytes are stored after the STOP.
- R5: After a STOP that commits data, the block does not acknowledge its select code for WRITE_CYCLES clocks. After that it acknowledges again.
- R6: A STOP that arrives in the middle of a byte stores nothing. The buffered page is discarded and no write cycle starts.
- R7: A random read is: write select byte, address byte, repeated START, read select byte. It returns the byte at that address, then the following bytes for as long as the master acknowledges. The counter wraps from DEPTH-1 to 0.
- R8: A master no-acknowledge followed by STOP ends a read. A later read select byte with no address returns the location after the last byte sent.
- R9: sda_oe (1 = pull SDA low) is first asserted only while SCL is low. It is never asserted in idle, or while the master drives data bits.
- R10: After reset, sda_oe is low and every location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock line |
| sda | input | 1 | Serial data line as seen on the bus |
| chip_en | input | 3 | Chip-enable value compared with select code bits 3:1 |
| wr_ctl | input | 1 | Write protect, high refuses data bytes |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
SCL and SDA are registered once, so a bus edge is seen on the clock edge after it appears. An acknowledge or a read data bit is driven one clock after the SCL fall that ends the previous bit. The bench samples the line in the middle of SCL high, six clocks after each SCL fall, so the sample lands well after that one-clock delay. The end of a write cycle is due WRITE_CYCLES clocks after the STOP. The bench polls once within about a hundred clocks of the STOP, expecting no answer, and again after WRITE_CYCLES plus ten clocks, expecting an answer. A reference memory in the bench predicts every read byte, and a per-clock check requires a released line whenever the master owns it.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int DEPTH        = 256,
  parameter int WRITE_CYCLES = 250000,
  parameter int PAGE         = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  input  logic [2:0] chip_en,
  input  logic       wr_ctl,
  output logic       sda_oe
);
  localparam int AW  = $clog2(DEPTH);
  localparam int HIW = AW - 8;
  localparam int PW  = $clog2(PAGE);
  localparam int CW  = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {IDLE, DEV, ADDR, WDATA, RDATA, SKIP} phase_t;

  phase_t          ph, nxt;
  logic            scl_q, sda_q, mack;
  logic [3:0]      cnt;
  logic [7:0]      sh, tx;
  logic [AW-1:0]   ptr;
  logic [2:0]      devlo;
  logic [PAGE-1:0] pvalid;
  logic [7:0]      pbuf [PAGE];
  logic [7:0]      mem  [DEPTH];
  logic [CW-1:0]   busy_cnt;
  logic            ce_ok;

  wire start_ev = scl && scl_q && sda_q && !sda;
  wire stop_ev  = scl && scl_q && !sda_q && sda;
  wire rise     = scl && !scl_q;
  wire fall     = !scl && scl_q;
  wire busy     = busy_cnt != '0;

  always_comb begin
    ce_ok = 1'b1;
    for (int i = HIW; i < 3; i++)
      if (sh[i+1] != chip_en[i]) ce_ok = 1'b0;
  end

  wire dev_hit = (sh[7:4] == 4'b1010) && ce_ok && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; ph <= IDLE; nxt <= IDLE;
      cnt <= '0; sh <= '0; tx <= '0; mack <= 1'b0; ptr <= '0; devlo <= '0;
      pvalid <= '0; busy_cnt <= '0; sda_oe <= 1'b0;
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
      for (int j = 0; j < PAGE; j++) pbuf[j] <= 8'h00;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (busy) begin
        busy_cnt <= busy_cnt - CW'(1);
        if (busy_cnt == CW'(1)) begin
          for (int j = 0; j < PAGE; j++)
            if (pvalid[j]) mem[{ptr[AW-1:PW], PW'(j)}] <= pbuf[j];
          pvalid <= '0;
        end
      end
      if (start_ev) begin
        ph <= DEV; cnt <= '0; sda_oe <= 1'b0;
        if (!busy) pvalid <= '0;
      end else if (stop_ev) begin
        ph <= IDLE; sda_oe <= 1'b0;
        // one rise (the STOP's own) past a byte boundary
        if (ph == WDATA && cnt <= 4'd1 && |pvalid) busy_cnt <= CW'(WRITE_CYCLES);
        else if (!busy) pvalid <= '0;
      end else if (ph == RDATA) begin
        if (rise) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd8) mack <= !sda;
        end
        if (fall) begin
          if (cnt >= 4'd1 && cnt <= 4'd7) sda_oe <= !tx[3'(4'd7 - cnt)];
          else if (cnt == 4'd8) sda_oe <= 1'b0;
          else if (cnt == 4'd9) begin
            if (mack) begin
              tx <= mem[ptr]; ptr <= ptr + AW'(1); sda_oe <= !mem[ptr][7]; cnt <= '0;
            end else ph <= SKIP;
          end
        end
      end else if (ph == DEV || ph == ADDR || ph == WDATA) begin
        if (rise && cnt < 4'd9) begin
          cnt <= cnt + 4'd1;
          if (cnt < 4'd8) sh <= {sh[6:0], sda};
        end
        if (fall && cnt == 4'd8) begin
          case (ph)
            DEV: if (dev_hit) begin
                   sda_oe <= 1'b1; devlo <= sh[3:1];
                   nxt <= sh[0] ? RDATA : ADDR;
                 end else nxt <= SKIP;
            ADDR: begin
                    sda_oe <= 1'b1; ptr <= AW'({devlo, sh}); nxt <= WDATA;
                  end
            default: begin
                       nxt <= WDATA;
                       if (!wr_ctl) begin
                         sda_oe <= 1'b1;
                         pbuf[ptr[PW-1:0]] <= sh;
                         pvalid[ptr[PW-1:0]] <= 1'b1;
                         ptr[PW-1:0] <= ptr[PW-1:0] + PW'(1);
                       end
                     end
          endcase
        end
        if (fall && cnt == 4'd9) begin
          sda_oe <= 1'b0; cnt <= '0; ph <= nxt;
          if (nxt == RDATA) begin
            tx <= mem[ptr]; ptr <= ptr + AW'(1); sda_oe <= !mem[ptr][7];
          end
        end
      end
    end
  end

  assert_pull_while_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == IDLE || ph == SKIP) |-> !sda_oe);
  assert_busy_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(ph inside {ADDR, WDATA, RDATA}));
  assert_protect_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == WDATA && fall && cnt == 4'd8 && wr_ctl) |=> !sda_oe);
  assert_commit_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));
endmodule

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int WRC   = 400;
  localparam int HALF  = 4;
  localparam logic [7:0] DEVW = 8'hAA;
  localparam logic [7:0] DEVR = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wr_ctl = 1'b0;
  logic [2:0] chip_en = 3'b101;
  logic sda_oe, sda_line;
  logic quiet = 1'b0;
  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];

  assign sda_line = m_sda & !sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_i2c_slave #(.DEPTH(DEPTH), .WRITE_CYCLES(WRC)) u_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl(m_scl), .sda(sda_line),
    .chip_en(chip_en), .wr_ctl(wr_ctl), .sda_oe(sda_oe));

  always @(negedge clk) if (rst_n && quiet) begin
    checks++;
    if (sda_oe) begin errors++; $display("FAIL R9 sda_oe actual 1 expected 0 at %0t", $time); end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %0h expected %0h", tag, act, exp); end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    m_sda = 1'b1; wt(HALF); m_scl = 1'b1; wt(HALF); m_sda = 1'b0; wt(HALF); m_scl = 1'b0; wt(HALF);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wt(HALF); m_scl = 1'b1; wt(HALF); m_sda = 1'b1; wt(HALF); quiet = 1'b1;
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(HALF);
      if (i == 7) quiet = 1'b1;
      m_scl = 1'b1; wt(HALF);
      if (i == 0) quiet = 1'b0;
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wt(HALF); m_scl = 1'b1; wt(2); ack = !sda_line; wt(2); m_scl = 1'b0; wt(1);
  endtask

  task automatic recv(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      wt(HALF); m_scl = 1'b1; wt(2); b[i] = sda_line; wt(2); m_scl = 1'b0;
    end
    m_sda = !mack; wt(HALF); m_scl = 1'b1; wt(HALF); m_scl = 1'b0; wt(1); m_sda = 1'b1;
  endtask

  task automatic poll(input bit exp, input string tag);
    bit a;
    i2c_start; send(DEVW, a); chk(a == exp, tag, a, exp); i2c_stop;
  endtask

  task automatic write_bytes(input int addr, input logic [7:0] d[$]);
    bit a;
    i2c_start;
    send(DEVW, a); chk(a, "R2 select ack", a, 1);
    send(8'(addr), a); chk(a, wr_ctl ? "R3 address ack" : "R4 address ack", a, 1);
    foreach (d[i]) begin
      send(d[i], a);
      chk(a == !wr_ctl, wr_ctl ? "R3 data nack" : "R4 data ack", a, !wr_ctl);
      if (!wr_ctl) model[(addr & ~15) | ((addr + i) & 15)] = d[i];
    end
    i2c_stop;
  endtask

  task automatic read_seq(input int addr, input int n, input string tag);
    bit a; logic [7:0] b;
    i2c_start; send(DEVW, a); chk(a, "R7 select ack", a, 1);
    send(8'(addr), a); chk(a, "R7 address ack", a, 1);
    i2c_start; send(DEVR, a); chk(a, "R1 restart select ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv(b, i < n - 1);
      chk(b == model[(addr + i) % DEPTH], tag, b, model[(addr + i) % DEPTH]);
    end
    i2c_stop;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++; $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors); $finish;
  end

  initial begin
    bit a; logic [7:0] b; logic [7:0] q[$];
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    wt(5); rst_n = 1'b1; wt(2); quiet = 1'b1;
    chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
    read_seq(8'h00, 2, "R10 erased content");
    // mismatched chip enable, then wrong prefix
    i2c_start; send(8'hA8, a); chk(!a, "R2 chip enable mismatch", a, 0); i2c_stop;
    i2c_start; send(8'hBA, a); chk(!a, "R2 prefix mismatch", a, 0); i2c_stop;
    // byte clocked without a START
    send(DEVW, a); chk(!a, "R1 no start no ack", a, 0); i2c_stop;
    // byte write with polling
    q = {8'h5A}; write_bytes(8'h10, q);
    poll(1'b0, "R5 busy poll nack");
    wt(WRC + 10);
    poll(1'b1, "R5 ready poll ack");
    read_seq(8'h10, 1, "R4 byte write");
    // page write with wrap inside page
    q = {};
    for (int i = 0; i < 19; i++) q.push_back(8'h30 + 8'(i));
    write_bytes(8'h25, q); wt(WRC + 10);
    read_seq(8'h20, 16, "R4 page wrap");
    // protected write
    wr_ctl = 1'b1; q = {8'h01, 8'h02, 8'h03}; write_bytes(8'h40, q); wr_ctl = 1'b0;
    poll(1'b1, "R3 no write cycle");
    read_seq(8'h40, 3, "R3 unchanged");
    // STOP in the middle of a byte
    i2c_start; send(DEVW, a); send(8'h50, a); send(8'h77, a);
    chk(a, "R6 data ack", a, 1);
    for (int i = 0; i < 3; i++) begin m_sda = 1'b0; wt(HALF); m_scl = 1'b1; wt(HALF); m_scl = 1'b0; end
    i2c_stop;
    poll(1'b1, "R6 no write cycle");
    read_seq(8'h50, 1, "R6 nothing stored");
    // wrap from last location to first
    q = {8'hEE, 8'hDD}; write_bytes(8'hFF, q); wt(WRC + 10);
    q = {8'h11}; write_bytes(8'h00, q); wt(WRC + 10);
    read_seq(8'hFE, 4, "R7 sequential wrap");
    // current address read after nack and STOP
    read_seq(8'h25, 2, "R7 random read");
    i2c_start; send(DEVR, a); chk(a, "R8 select ack", a, 1);
    recv(b, 1'b0); chk(b == model[8'h27], "R8 current address", b, model[8'h27]);
    i2c_stop;
    wt(4);
    chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule